// File: doc/BRIEF.md
# Boost Stage Duty-Cycle Regulator

This block sets the switch duty cycle of a DC-DC boost stage and produces the gate PWM from it. While awake, each finished output-voltage conversion is compared with a tolerance window around the target. A reading below the window lengthens the duty code by one step. A reading above it shortens the code by one step. A reading inside the window leaves the code alone. If a correction is needed but the code already sits at its usable limit, that sample counts as a limit failure. Five limit failures in a row put the block to sleep.

While asleep, the PWM output stays low. Only the input-voltage converter is enabled. A periodic timer tick arms a single input-voltage check. If the input has reached the wake threshold, the block wakes, restarts from the mid duty code and hands the converter enable back to the output channel. The PWM comparator picks up a new duty code only at the start of a PWM period, so no period is ever cut short or stretched.

Top module: `boost_duty_ctl`

## Requirements
- R1: After reset the block is awake (`asleep`=0), `duty_code`=7, `fail_count`=0, `vout_adc_en`=1 and `vin_adc_en`=0.
- R2: While awake, an output sample with VOUT_LO ≤ code ≤ VOUT_HI (550..650 by default, bounds inclusive) leaves `duty_code` unchanged and clears `fail_count`. Without a `vout_valid` strobe, neither value changes.
- R3: While awake, an output sample below VOUT_LO raises `duty_code` by one when it is below DUTY_MAX (14), and clears `fail_count`.
- R4: While awake, an output sample above VOUT_HI lowers `duty_code` by one when it is above DUTY_MIN (1), and clears `fail_count`.
- R5: A low sample at DUTY_MAX, or a high sample at DUTY_MIN, leaves `duty_code` unchanged and raises `fail_count` by one.
- R6: The fifth consecutive limit failure sets `asleep`=1 and clears `fail_count`. Any in-window or correctable sample in between restarts the count from zero.
- R7: While asleep, `pwm_out`=0, `vout_adc_en`=0 and `vin_adc_en`=1, and output samples have no effect on `duty_code`.
- R8: While asleep, an input sample is evaluated only if a `wake_tick` has arrived since the last evaluation. An input below VIN_WAKE (175) keeps the block asleep, and an input sample without a pending tick is ignored.
- R9: An evaluated input sample ≥ VIN_WAKE wakes the block with `duty_code`=7, `fail_count`=0, `vout_adc_en`=1 and `vin_adc_en`=0.
- R10: The PWM period is 2^(DUTY_W+PWM_SUB_W) = 64 cycles. `pwm_out` is high for the first `duty_code`×4 cycles of each period. A duty change takes effect only at the start of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vout_sample | input | SAMPLE_W | Output-voltage conversion result |
| vout_valid | input | 1 | One-cycle strobe, output conversion done |
| vin_sample | input | SAMPLE_W | Input-voltage conversion result |
| vin_valid | input | 1 | One-cycle strobe, input conversion done |
| wake_tick | input | 1 | Periodic timer tick used while asleep |
| vout_adc_en | output | 1 | Enable for the output-voltage converter |
| vin_adc_en | output | 1 | Enable for the input-voltage converter |
| pwm_out | output | 1 | Gate drive for the boost switch |
| asleep | output | 1 | 1 while in sleep mode |
| fail_count | output | FAIL_W | Consecutive limit failures so far |
| duty_code | output | DUTY_W | Current duty code |

## Verification
The hardest condition to reach is the sleep entry. It needs the duty code walked all the way to a limit with single-step corrections, followed by five back-to-back uncorrectable samples with no in-window sample among them. The stimulus first steps the code to the top limit with a run of low readings. It then breaks a partial failure run with an in-window sample and with a correctable high sample, and only after that applies the uninterrupted run of five. The same walk is repeated toward the bottom limit. The deferred PWM update is checked by locking onto the rising edge of `pwm_out`, which marks a period start, and changing the duty code in the middle of a period.

// File: rtl/boost_ctl_pkg.sv
// Shared types for the boost duty regulator.
// Assumes: nothing beyond the SystemVerilog base types.
package boost_ctl_pkg;
    // Position of a sample relative to the regulation window.
    typedef enum logic [1:0] {
        WIN_INSIDE = 2'd0,
        WIN_BELOW  = 2'd1,
        WIN_ABOVE  = 2'd2
    } win_cls_t;

    // Operating mode of the controller.
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_REST = 1'b1
    } op_mode_t;
endpackage

// File: rtl/win_classify.sv
// Places an output-voltage code below, inside or above [LO, HI] (bounds inclusive).
// Assumes: LO <= HI. Purely combinational.
module win_classify
    import boost_ctl_pkg::*;
#(
    parameter int unsigned           SAMPLE_W = 10,
    parameter logic [SAMPLE_W-1:0]   LO       = SAMPLE_W'(550),
    parameter logic [SAMPLE_W-1:0]   HI       = SAMPLE_W'(650)
) (
    input  logic [SAMPLE_W-1:0] sample,
    output win_cls_t            cls
);
    // Decide the window position of the sample.
    always_comb begin
        if (sample < LO)      cls = WIN_BELOW;
        else if (sample > HI) cls = WIN_ABOVE;
        else                  cls = WIN_INSIDE;
    end
endmodule

// File: rtl/wake_monitor.sv
// Tick-armed input-voltage check used while asleep. A tick arms one check, and the
// next input strobe consumes it. The check asks for a wake when the input reaches THRESH.
// Assumes: asleep comes from a register. A tick and a strobe in the same cycle count as armed.
module wake_monitor #(
    parameter int unsigned         SAMPLE_W = 10,
    parameter logic [SAMPLE_W-1:0] THRESH   = SAMPLE_W'(175)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                asleep,
    input  logic                tick,
    input  logic [SAMPLE_W-1:0] vin,
    input  logic                vin_valid,
    output logic                wake_go
);
    logic armed;
    logic check;

    assign check   = asleep && vin_valid && (armed || tick);
    assign wake_go = check && (vin >= THRESH);

    // Hold a pending tick until an input strobe consumes it. Cleared while awake.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (!asleep) armed <= 1'b0;
        else if (check)   armed <= 1'b0;
        else if (tick)    armed <= 1'b1;
    end
endmodule

// File: rtl/duty_regulator.sv
// Holds the mode, the duty code and the consecutive limit-failure count.
// While running, it steps the duty code once per output strobe, toward the window.
// It rests after FAIL_LIMIT failures in a row and restarts at MID when asked to wake.
// Assumes: MIN <= MID <= MAX and FAIL_LIMIT >= 1.
module duty_regulator
    import boost_ctl_pkg::*;
#(
    parameter int unsigned       DUTY_W     = 4,
    parameter logic [DUTY_W-1:0] MIN        = DUTY_W'(1),
    parameter logic [DUTY_W-1:0] MAX        = DUTY_W'(14),
    parameter logic [DUTY_W-1:0] MID        = DUTY_W'(7),
    parameter int unsigned       FAIL_LIMIT = 5,
    parameter int unsigned       FAIL_W     = $clog2(FAIL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  win_cls_t          cls,
    input  logic              wake_go,
    output op_mode_t          mode,
    output logic [DUTY_W-1:0] duty,
    output logic [FAIL_W-1:0] fails
);
    localparam logic [FAIL_W-1:0] FAIL_LAST = FAIL_W'(FAIL_LIMIT - 1);

    logic at_limit;

    // A correction is needed but the code already sits at the matching limit.
    assign at_limit = ((cls == WIN_BELOW) && (duty >= MAX)) ||
                      ((cls == WIN_ABOVE) && (duty <= MIN));

    // Mode, duty code and failure count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_RUN;
            duty  <= MID;
            fails <= '0;
        end else if (mode == MODE_REST) begin
            if (wake_go) begin
                mode  <= MODE_RUN;
                duty  <= MID;
                fails <= '0;
            end
        end else if (eval) begin
            if (at_limit) begin
                if (fails == FAIL_LAST) begin
                    mode  <= MODE_REST;
                    fails <= '0;
                end else begin
                    fails <= fails + 1'b1;
                end
            end else begin
                fails <= '0;
                if (cls == WIN_BELOW)      duty <= duty + 1'b1;
                else if (cls == WIN_ABOVE) duty <= duty - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_gen.sv
// Free-running PWM. The counter spans 2^(DUTY_W+SUB_W) cycles, so one duty step is
// 2^SUB_W cycles of high time. The duty code is copied into a shadow register on the
// last count of each period and is used from the next period on.
// Assumes: the output is forced low when enable is 0. The counter keeps running.
module pwm_gen #(
    parameter int unsigned       DUTY_W = 4,
    parameter int unsigned       SUB_W  = 2,
    parameter logic [DUTY_W-1:0] INIT   = DUTY_W'(7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm
);
    localparam int unsigned CNT_W = DUTY_W + SUB_W;

    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] shadow;

    assign pwm = enable && (cnt < {shadow, {SUB_W{1'b0}}});

    // Period counter, plus the shadow duty loaded at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            shadow <= INIT;
        end else begin
            cnt <= cnt + 1'b1;
            if (&cnt) shadow <= duty;
        end
    end
endmodule

// File: rtl/boost_duty_ctl.sv
// Top of the boost duty regulator. It joins the window classifier, the tick-armed wake
// monitor, the duty/mode regulator and the PWM generator, and derives the converter
// enables from the mode.
// Assumes: valid strobes last one cycle per conversion. Sample codes are unsigned.
module boost_duty_ctl
    import boost_ctl_pkg::*;
#(
    parameter int unsigned SAMPLE_W   = 10,
    parameter int unsigned DUTY_W     = 4,
    parameter int unsigned PWM_SUB_W  = 2,
    parameter int unsigned VOUT_LO    = 550,
    parameter int unsigned VOUT_HI    = 650,
    parameter int unsigned VIN_WAKE   = 175,
    parameter int unsigned DUTY_MIN   = 1,
    parameter int unsigned DUTY_MAX   = 14,
    parameter int unsigned DUTY_MID   = 7,
    parameter int unsigned FAIL_LIMIT = 5,
    parameter int unsigned FAIL_W     = $clog2(FAIL_LIMIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] vout_sample,
    input  logic                vout_valid,
    input  logic [SAMPLE_W-1:0] vin_sample,
    input  logic                vin_valid,
    input  logic                wake_tick,
    output logic                vout_adc_en,
    output logic                vin_adc_en,
    output logic                pwm_out,
    output logic                asleep,
    output logic [FAIL_W-1:0]   fail_count,
    output logic [DUTY_W-1:0]   duty_code
);
    localparam logic [SAMPLE_W-1:0] LO_C   = SAMPLE_W'(VOUT_LO);
    localparam logic [SAMPLE_W-1:0] HI_C   = SAMPLE_W'(VOUT_HI);
    localparam logic [SAMPLE_W-1:0] WAKE_C = SAMPLE_W'(VIN_WAKE);
    localparam logic [DUTY_W-1:0]   MIN_C  = DUTY_W'(DUTY_MIN);
    localparam logic [DUTY_W-1:0]   MAX_C  = DUTY_W'(DUTY_MAX);
    localparam logic [DUTY_W-1:0]   MID_C  = DUTY_W'(DUTY_MID);

    win_cls_t cls;
    op_mode_t mode;
    logic     wake_go;

    win_classify #(.SAMPLE_W(SAMPLE_W), .LO(LO_C), .HI(HI_C)) cls_i (
        .sample (vout_sample),
        .cls    (cls)
    );

    wake_monitor #(.SAMPLE_W(SAMPLE_W), .THRESH(WAKE_C)) wake_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .asleep    (asleep),
        .tick      (wake_tick),
        .vin       (vin_sample),
        .vin_valid (vin_valid),
        .wake_go   (wake_go)
    );

    duty_regulator #(
        .DUTY_W(DUTY_W), .MIN(MIN_C), .MAX(MAX_C), .MID(MID_C),
        .FAIL_LIMIT(FAIL_LIMIT), .FAIL_W(FAIL_W)
    ) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval    (vout_valid),
        .cls     (cls),
        .wake_go (wake_go),
        .mode    (mode),
        .duty    (duty_code),
        .fails   (fail_count)
    );

    pwm_gen #(.DUTY_W(DUTY_W), .SUB_W(PWM_SUB_W), .INIT(MID_C)) pwm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!asleep),
        .duty   (duty_code),
        .pwm    (pwm_out)
    );

    assign asleep      = (mode == MODE_REST);
    assign vout_adc_en = !asleep;
    assign vin_adc_en  = asleep;
endmodule

// File: rtl/boost_duty_ctl_chk.sv
// Temporal checks on the boost duty regulator, bound to every instance of the top.
// Assumes: reset is held for at least one clock edge.
module boost_duty_ctl_chk #(
    parameter int unsigned SAMPLE_W   = 10,
    parameter int unsigned DUTY_W     = 4,
    parameter int unsigned VIN_WAKE   = 175,
    parameter int unsigned DUTY_MIN   = 1,
    parameter int unsigned DUTY_MAX   = 14,
    parameter int unsigned DUTY_MID   = 7,
    parameter int unsigned FAIL_LIMIT = 5,
    parameter int unsigned FAIL_W     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                vout_valid,
    input logic [SAMPLE_W-1:0] vin_sample,
    input logic                vin_valid,
    input logic                vout_adc_en,
    input logic                vin_adc_en,
    input logic                pwm_out,
    input logic                asleep,
    input logic [FAIL_W-1:0]   fail_count,
    input logic [DUTY_W-1:0]   duty_code
);
    // No strobe while awake: code and count hold.
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !vout_valid) |=> ($stable(duty_code) && $stable(fail_count)));

    // While awake, the code moves by at most one step per cycle.
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |=> (asleep || int'(duty_code) == int'($past(duty_code)) ||
                     int'(duty_code) == int'($past(duty_code)) + 1 ||
                     int'(duty_code) == int'($past(duty_code)) - 1));

    // The code never leaves its usable range.
    p_duty_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(duty_code) >= DUTY_MIN && int'(duty_code) <= DUTY_MAX));

    // The failure count stays below the limit.
    p_fail_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fail_count) < FAIL_LIMIT);

    // Sleep is entered only from the last failure before the limit, on a strobe.
    p_sleep_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> (int'($past(fail_count)) == FAIL_LIMIT - 1 && $past(vout_valid)
                           && fail_count == '0));

    // Asleep: gate low and enables swapped.
    p_sleep_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!pwm_out && !vout_adc_en && vin_adc_en));

    // Asleep: duty code frozen.
    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (!asleep || $stable(duty_code)));

    // Asleep without an input strobe: stays asleep.
    p_stay_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !vin_valid) |=> asleep);

    // Waking follows a qualifying input sample and restarts at the mid code.
    p_wake_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (int'(duty_code) == DUTY_MID && fail_count == '0 &&
                           $past(vin_valid) && int'($past(vin_sample)) >= VIN_WAKE));
endmodule

bind boost_duty_ctl boost_duty_ctl_chk #(
    .SAMPLE_W(SAMPLE_W), .DUTY_W(DUTY_W), .VIN_WAKE(VIN_WAKE),
    .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .DUTY_MID(DUTY_MID),
    .FAIL_LIMIT(FAIL_LIMIT), .FAIL_W(FAIL_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .vout_valid(vout_valid), .vin_sample(vin_sample),
    .vin_valid(vin_valid), .vout_adc_en(vout_adc_en), .vin_adc_en(vin_adc_en),
    .pwm_out(pwm_out), .asleep(asleep), .fail_count(fail_count), .duty_code(duty_code)
);

// File: tb/boost_duty_ctl_tb_top.sv
// Directed bench for the boost duty regulator. Each task drives one scenario and checks it.
module boost_duty_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vout_sample = '0;
    logic       vout_valid = 1'b0;
    logic [9:0] vin_sample = '0;
    logic       vin_valid = 1'b0;
    logic       wake_tick = 1'b0;
    logic       vout_adc_en, vin_adc_en, pwm_out, asleep;
    logic [2:0] fail_count;
    logic [3:0] duty_code;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    boost_duty_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .vout_sample(vout_sample), .vout_valid(vout_valid),
        .vin_sample(vin_sample), .vin_valid(vin_valid), .wake_tick(wake_tick),
        .vout_adc_en(vout_adc_en), .vin_adc_en(vin_adc_en), .pwm_out(pwm_out),
        .asleep(asleep), .fail_count(fail_count), .duty_code(duty_code)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_vout(input int v);
        @(negedge clk); vout_sample = 10'(v); vout_valid = 1'b1;
        @(negedge clk); vout_valid = 1'b0;
    endtask

    task automatic send_vin(input int v);
        @(negedge clk); vin_sample = 10'(v); vin_valid = 1'b1;
        @(negedge clk); vin_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); wake_tick = 1'b1;
        @(negedge clk); wake_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "asleep", int'(asleep), 0);
        chk("R1", "duty", int'(duty_code), 7);
        chk("R1", "fails", int'(fail_count), 0);
        chk("R1", "vout_en", int'(vout_adc_en), 1);
        chk("R1", "vin_en", int'(vin_adc_en), 0);
    endtask

    task automatic t_window();
        send_vout(550); chk("R2", "duty at low edge", int'(duty_code), 7);
        send_vout(600); chk("R2", "duty mid window", int'(duty_code), 7);
        send_vout(650); chk("R2", "duty at high edge", int'(duty_code), 7);
        repeat (5) @(negedge clk);
        chk("R2", "duty idle", int'(duty_code), 7);
        send_vout(549); chk("R3", "duty after low", int'(duty_code), 8);
        send_vout(651); chk("R4", "duty after high", int'(duty_code), 7);
    endtask

    task automatic t_pwm();
        int h;
        bit prev;
        prev = pwm_out;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
        h = int'(pwm_out);
        for (int i = 0; i < 63; i++) begin @(negedge clk); h += int'(pwm_out); end
        chk("R10", "high cycles duty 7", h, 28);
        repeat (21) @(negedge clk);
        vout_sample = 10'd500; vout_valid = 1'b1;
        h = 0;
        for (int i = 0; i < 43; i++) begin
            @(negedge clk);
            vout_valid = 1'b0;
            h += int'(pwm_out);
        end
        chk("R10", "rest of period keeps old duty", h, 7);
        chk("R3", "duty raised mid period", int'(duty_code), 8);
        h = 0;
        for (int i = 0; i < 64; i++) begin @(negedge clk); h += int'(pwm_out); end
        chk("R10", "high cycles duty 8", h, 32);
        send_vout(700); chk("R4", "duty back", int'(duty_code), 7);
    endtask

    task automatic t_fail_restart();
        for (int i = 0; i < 7; i++) send_vout(400);
        chk("R3", "duty at max", int'(duty_code), 14);
        send_vout(400); send_vout(400);
        chk("R5", "duty held at max", int'(duty_code), 14);
        chk("R5", "fails two", int'(fail_count), 2);
        send_vout(600);
        chk("R6", "window clears fails", int'(fail_count), 0);
        send_vout(400); send_vout(400); send_vout(800);
        chk("R6", "correction clears fails", int'(fail_count), 0);
        chk("R4", "duty after correction", int'(duty_code), 13);
        send_vout(400);
        chk("R3", "duty back to max", int'(duty_code), 14);
    endtask

    task automatic t_sleep_top();
        int h;
        for (int i = 0; i < 4; i++) send_vout(300);
        chk("R5", "fails four", int'(fail_count), 4);
        chk("R6", "still awake at four", int'(asleep), 0);
        send_vout(300);
        chk("R6", "asleep at five", int'(asleep), 1);
        chk("R6", "fails cleared", int'(fail_count), 0);
        chk("R7", "vout_en off", int'(vout_adc_en), 0);
        chk("R7", "vin_en on", int'(vin_adc_en), 1);
        h = 0;
        for (int i = 0; i < 64; i++) begin @(negedge clk); h += int'(pwm_out); end
        chk("R7", "pwm high cycles asleep", h, 0);
        send_vout(100); send_vout(900);
        chk("R7", "duty frozen asleep", int'(duty_code), 14);
        send_vin(400);
        chk("R8", "untimed vin ignored", int'(asleep), 1);
        tick(); send_vin(174);
        chk("R8", "below threshold stays", int'(asleep), 1);
        send_vin(300);
        chk("R8", "tick consumed", int'(asleep), 1);
        tick(); send_vin(175);
        chk("R9", "wake at threshold", int'(asleep), 0);
        chk("R9", "duty mid", int'(duty_code), 7);
        chk("R9", "fails zero", int'(fail_count), 0);
        chk("R9", "vout_en on", int'(vout_adc_en), 1);
        chk("R9", "vin_en off", int'(vin_adc_en), 0);
    endtask

    task automatic t_sleep_bottom();
        for (int i = 0; i < 6; i++) send_vout(1000);
        chk("R4", "duty at min", int'(duty_code), 1);
        for (int i = 0; i < 4; i++) send_vout(1000);
        chk("R5", "duty held at min", int'(duty_code), 1);
        chk("R5", "fails four low side", int'(fail_count), 4);
        send_vout(1000);
        chk("R6", "asleep low side", int'(asleep), 1);
        tick(); send_vin(500);
        chk("R9", "wake again", int'(asleep), 0);
        chk("R9", "duty mid again", int'(duty_code), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_pwm();
        t_fail_restart();
        t_sleep_top();
        t_sleep_bottom();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule